// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in front of a sample-rate converter FIFO. It scales a stream of signed audio samples by a gain that changes one step at a time, and it moves toward silence or back toward unity in a straight line. The gain is held in a saturating counter. The counter steps once per input word-clock event, which arrives as a single-cycle strobe in the system clock domain, and does not step on every system clock. While the mute request is high, the gain falls toward zero. While it is low, the gain rises toward full scale. A full sweep in either direction takes 2^CNT_W strobes, which is 4096 with the default width.

When the block comes out of reset the gain is at full attenuation, so audio fades in. A separate mute-status output goes high on reset and on every rate-change pulse. It stays high until a settling-done flag arrives from the servo loop. The reset input is filtered: it takes effect only after it has been held low for RST_MIN consecutive system clocks, and shorter low pulses are ignored.

Top module: `soft_mute_ramp`

## Requirements
- R1: Internal reset takes effect only when rst_ni has been low for RST_MIN (default 5) consecutive clock edges. A shorter low pulse changes neither the gain nor the mute status.
- R2: After reset the gain is 0 (full attenuation), mute_stat_o is 1 and valid_o is 0.
- R3: The gain stays within 0 to 2^CNT_W inclusive. It saturates at both ends and never wraps.
- R4: On each stb_i the gain moves by one step: down when mute_i=1 and up when mute_i=0. Without a strobe it holds its value. A change of mute_i part way through a ramp reverses the direction from the current gain.
- R5: Each output sample equals data_i*gain/2^CNT_W in two's complement, truncated toward zero. A gain of 2^CNT_W passes data_i unchanged, and a gain of 0 gives exactly 0.
- R6: data_o is registered one clock after stb_i and uses the gain from before that strobe's step. valid_o is 1 in exactly the cycle after each strobe and 0 otherwise.
- R7: Starting from gain 0 with mute released, unity gain is reached after exactly 2^CNT_W strobes. The reverse direction takes the same number.
- R8: mute_stat_o is set the clock after rate_chg_i=1 and cleared the clock after settle_done_i=1. When both are high in the same cycle, the rate change wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, filtered over RST_MIN clocks |
| stb_i | input | 1 | One-cycle input word-clock event |
| mute_i | input | 1 | Mute request (1 = ramp down) |
| rate_chg_i | input | 1 | Rate-change indication pulse |
| settle_done_i | input | 1 | Servo has left fast settling |
| data_i | input | DATA_W | Signed input sample |
| data_o | output | DATA_W | Signed scaled sample |
| valid_o | output | 1 | data_o valid pulse |
| mute_stat_o | output | 1 | Mute status |

## Verification
The bench builds the block with DATA_W=8, CNT_W=4 and RST_MIN=5. A full ramp is then 16 strobes, so many complete down-and-up cycles fit in a short run, and every gain level gets multiplied against a wide spread of the 256 possible samples, including -128 and 127. At the two saturated gains the bench sweeps all 256 input values. Saturation, reversal in mid-ramp, the reset-length threshold (3 cycles against 8) and the priority between rate change and settling-done are all reached directly.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;
  typedef enum logic {
    RAMP_UP   = 1'b0,
    RAMP_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/smr_rst_filter.sv
module smr_rst_filter #(
  parameter int RST_MIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_act_o
);
  logic [RST_MIN-1:0] hist_q;

  always_ff @(posedge clk_i) begin
    hist_q <= {hist_q[RST_MIN-2:0], rst_ni};
  end

  // reset only after RST_MIN consecutive low samples
  assign rst_act_o = ~|hist_q;
endmodule

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp
  import soft_mute_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_act_i,
  input  logic           stb_i,
  input  ramp_dir_e      dir_i,
  output logic [CNT_W:0] gain_o
);
  localparam int GAIN_W = CNT_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = GAIN_W'(1) << CNT_W;

  logic [GAIN_W-1:0] gain_q;

  always_ff @(posedge clk_i) begin
    if (rst_act_i) begin
      gain_q <= '0;
    end else if (stb_i) begin
      unique case (dir_i)
        RAMP_UP:   if (gain_q != GAIN_MAX) gain_q <= gain_q + 1'b1;
        RAMP_DOWN: if (gain_q != '0)       gain_q <= gain_q - 1'b1;
        default:   gain_q <= gain_q;
      endcase
    end
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_act_i,
  input  logic                     stb_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic        [CNT_W:0]    gain_i,
  output logic signed [DATA_W-1:0] data_o,
  output logic                     valid_o
);
  localparam int PROD_W = DATA_W + CNT_W + 2;
  localparam logic signed [PROD_W-1:0] RND_BIAS = PROD_W'((64'd1 << CNT_W) - 64'd1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    prod    = PROD_W'(data_i) * $signed({1'b0, gain_i});
    // bias negatives so the arithmetic shift truncates toward zero
    biased  = prod[PROD_W-1] ? prod + RND_BIAS : prod;
    shifted = biased >>> CNT_W;
  end

  always_ff @(posedge clk_i) begin
    if (rst_act_i) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= stb_i;
      if (stb_i) data_o <= shifted[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/smr_status.sv
module smr_status (
  input  logic clk_i,
  input  logic rst_act_i,
  input  logic rate_chg_i,
  input  logic settle_done_i,
  output logic mute_stat_o
);
  always_ff @(posedge clk_i) begin
    if (rst_act_i)          mute_stat_o <= 1'b1;
    else if (rate_chg_i)    mute_stat_o <= 1'b1;
    else if (settle_done_i) mute_stat_o <= 1'b0;
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import soft_mute_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int CNT_W   = 12,
  parameter int RST_MIN = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stb_i,
  input  logic                     mute_i,
  input  logic                     rate_chg_i,
  input  logic                     settle_done_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [DATA_W-1:0] data_o,
  output logic                     valid_o,
  output logic                     mute_stat_o
);
  logic           rst_act;
  logic [CNT_W:0] gain;
  ramp_dir_e      dir;

  assign dir = mute_i ? RAMP_DOWN : RAMP_UP;

  smr_rst_filter #(.RST_MIN(RST_MIN)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_act_o (rst_act)
  );

  smr_gain_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk_i     (clk_i),
    .rst_act_i (rst_act),
    .stb_i     (stb_i),
    .dir_i     (dir),
    .gain_o    (gain)
  );

  smr_scaler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_scale (
    .clk_i     (clk_i),
    .rst_act_i (rst_act),
    .stb_i     (stb_i),
    .data_i    (data_i),
    .gain_i    (gain),
    .data_o    (data_o),
    .valid_o   (valid_o)
  );

  smr_status u_stat (
    .clk_i         (clk_i),
    .rst_act_i     (rst_act),
    .rate_chg_i    (rate_chg_i),
    .settle_done_i (settle_done_i),
    .mute_stat_o   (mute_stat_o)
  );
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input logic              clk_i,
  input logic              rst_act,
  input logic              stb_i,
  input logic              mute_i,
  input logic              rate_chg_i,
  input logic [CNT_W:0]    gain,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              mute_stat_o
);
  localparam logic [CNT_W:0] GAIN_MAX = (CNT_W+1)'(1) << CNT_W;

  logic armed = 1'b0;
  always @(posedge clk_i) if (rst_act === 1'b1) armed <= 1'b1;

  a_r3_gain_range: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    gain <= GAIN_MAX);

  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    (stb_i && mute_i && gain != '0) |=> gain == $past(gain) - 1'b1);

  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    (stb_i && !mute_i && gain != GAIN_MAX) |=> gain == $past(gain) + 1'b1);

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    !stb_i |=> $stable(gain));

  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    stb_i |=> valid_o);

  a_r6_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    !stb_i |=> !valid_o);

  a_r5_zero_gain: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    (stb_i && gain == '0) |=> data_o == '0);

  a_r8_rate_sets: assert property (@(posedge clk_i) disable iff (!armed || rst_act)
    rate_chg_i |=> mute_stat_o);

  a_r2_reset_state: assert property (@(posedge clk_i) disable iff (!armed)
    rst_act |=> (gain == '0 && mute_stat_o && !valid_o));
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_act     (rst_act),
  .stb_i       (stb_i),
  .mute_i      (mute_i),
  .rate_chg_i  (rate_chg_i),
  .gain        (gain),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .mute_stat_o (mute_stat_o)
);

// File: tb/tb_soft_mute_ramp.sv
module tb_soft_mute_ramp;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 4;
  localparam int RST_MIN = 5;
  localparam int FULL    = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic stb = 1'b0, mute = 1'b0, rate_chg = 1'b0, settle = 1'b0;
  logic signed [DATA_W-1:0] din = '0;
  logic signed [DATA_W-1:0] dout;
  logic valid, mstat;

  int n_chk = 0, n_fail = 0;
  int g = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_mute_ramp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RST_MIN(RST_MIN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .stb_i(stb), .mute_i(mute),
    .rate_chg_i(rate_chg), .settle_done_i(settle), .data_i(din),
    .data_o(dout), .valid_o(valid), .mute_stat_o(mstat)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one strobe, check output against the model, then step the model
  task automatic strobe(input int d, input string req);
    @(negedge clk);
    stb = 1'b1; din = DATA_W'(d);
    @(negedge clk);
    stb = 1'b0;
    check(req, int'(dout), (d * g) / FULL);
    check("R6 valid", int'(valid), 1);
    if (mute) g = (g > 0) ? g - 1 : 0;
    else      g = (g < FULL) ? g + 1 : FULL;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk); rst_ni = 1'b0;
    repeat (cycles) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset(8);
    g = 0;
    check("R2 status", int'(mstat), 1);
    check("R2 valid", int'(valid), 0);
    @(negedge clk);
    check("R6 no strobe no valid", int'(valid), 0);

    // R7: 16 strobes from 0 reach unity; strobe 16 still uses gain 15
    for (int i = 0; i < FULL; i++) strobe(127, "R7 ramp up");
    check("R7 unity reached", g, FULL);
    strobe(127, "R7 unity passes");
    check("R5 unity", int'(dout), 127);

    // R5: all samples at unity gain
    for (int d = -128; d < 128; d++) strobe(d, "R5 unity sweep");

    // R3: saturate at top
    for (int i = 0; i < 4; i++) strobe(-128, "R3 top saturation");

    // R4/R5: many full down/up cycles with varied data
    for (int p = 0; p < 16; p++) begin
      mute = 1'b1;
      for (int i = 0; i <= FULL; i++) strobe(((i * 37 + p * 11) % 256) - 128, "R5 ramp down");
      mute = 1'b0;
      for (int i = 0; i <= FULL; i++) strobe(((i * 53 + p * 29) % 256) - 128, "R5 ramp up");
    end

    // R3/R5: floor, all samples give zero
    mute = 1'b1;
    for (int i = 0; i <= FULL + 2; i++) strobe(-128, "R3 bottom saturation");
    check("R3 floor", g, 0);
    for (int d = -128; d < 128; d++) strobe(d, "R5 zero gain sweep");

    // R4: reversal mid-ramp
    mute = 1'b0;
    for (int i = 0; i < 7; i++) strobe(100, "R4 up");
    mute = 1'b1;
    for (int i = 0; i < 3; i++) strobe(-100, "R4 reverse down");
    mute = 1'b0;
    for (int i = 0; i < 4; i++) strobe(-77, "R4 reverse up");

    // R4: no strobe, gain holds (observed via next output)
    repeat (20) @(negedge clk);
    strobe(127, "R4 hold without strobe");

    // R8: status control
    @(negedge clk); settle = 1'b1; @(negedge clk); settle = 1'b0;
    check("R8 settle clears", int'(mstat), 0);
    @(negedge clk); rate_chg = 1'b1; @(negedge clk); rate_chg = 1'b0;
    check("R8 rate sets", int'(mstat), 1);
    @(negedge clk); settle = 1'b1; @(negedge clk); settle = 1'b0;
    check("R8 settle clears again", int'(mstat), 0);
    @(negedge clk); settle = 1'b1; rate_chg = 1'b1;
    @(negedge clk); settle = 1'b0; rate_chg = 1'b0;
    check("R8 rate wins", int'(mstat), 1);
    @(negedge clk); settle = 1'b1; @(negedge clk); settle = 1'b0;

    // R1: short reset ignored
    for (int i = 0; i < FULL; i++) strobe(50, "R1 prep");
    do_reset(3);
    check("R1 short pulse status", int'(mstat), 0);
    strobe(127, "R1 short pulse keeps gain");
    check("R1 gain kept", int'(dout), 127);

    // R1/R2: long reset acts
    do_reset(RST_MIN + 1);
    g = 0;
    check("R1 long pulse status", int'(mstat), 1);
    check("R2 valid after reset", int'(valid), 0);
    strobe(127, "R2 gain zero after reset");

    done = 1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule